// File: doc/BRIEF.md
# Drum Parameter Memory Scan Sequencer

This block walks continuously through a small parameter memory that is four bits wide. It passes every stored value to one shared DAC, and analog demultiplexers then route that value to the voices. A clock-enable input, `tick`, advances a scan counter. The counter forms the nibble address, and a 3-bit program code is placed above it to choose the memory bank. Every parameter slot lasts four scan positions. The low nibble is read first and the high nibble second. The two are joined into one 8-bit value, and a one-clock load strobe goes to the DAC.

The block also drives a 3-bit parameter select for the demultiplexers and five active-low voice enables. A voice enable stays inactive during the two positions of a slot that come before the load and during the position right after it, so the analog side never sees a DAC output that is still settling. After 160 positions the scan returns to the start (5 voices, 8 parameters each, 4 positions per parameter). A separate 3-bit kit code is taken from input pins on a rising edge of a trigger input.

Top module: `drumScanSeq`

## Requirements
- R1: While `rst` is high and after it is released, these outputs hold their cleared values: `dacValue` = 0, `dacLoad` = 0, `voiceEnN` = 5'b11111, `kitCode` = 0, and the scan position is 0 (`memAddr[6:0]` = 0).
- R2: The scan position advances by one on each clock edge where `tick` is high, and only on those edges. When `tick` is low, `memAddr[6:0]` and `paramSel` keep their values.
- R3: With scan position p, `memAddr[0]` = p mod 2 (this is the nibble select) and `memAddr[6:1]` = p div 4 (this is the parameter index). Bit 1 of the position is not used in the address, so each slot presents low, high, low, high.
- R4: After position 159 the next tick returns the scan to position 0, which is parameter 0 of voice 0, low nibble.
- R5: `memAddr[9:7]` always equals `progSel`, unchanged. Code 0 selects bank 0 (program 8) and codes 1 to 7 select banks 1 to 7.
- R6: The tick at slot position 0 latches `memData` as the low nibble. The tick at position 1 makes `dacValue` = {`memData`, low nibble}. The repeated reads at positions 2 and 3 do not change `dacValue`.
- R7: `dacLoad` is high for exactly one clock, namely the clock that follows the edge where the high nibble is captured. That is the same edge on which `dacValue` takes its new value.
- R8: `paramSel` = (p div 4) mod 8. The voice number is (p div 4) div 8, so each voice's eight parameters are scanned before the next voice starts.
- R9: `voiceEnN[v]` is low exactly while the scan position is at slot position 3 of a parameter belonging to voice v. At most one enable is low at any time, and all enables are high while `dacLoad` is high.
- R10: `kitCode` takes the value of `kitBits` on a clock edge where `kitTrig` is high and was low at the previous edge. At every other edge `kitCode` keeps its value, including while `kitTrig` stays high.
- R11: Reset is synchronous and takes priority over `tick` and `kitTrig` when they arrive in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Clock enable that steps the scan position |
| progSel | input | 3 | Program bank code (0 selects program 8) |
| memData | input | 4 | Nibble read from the parameter memory |
| kitBits | input | 3 | Kit code presented on the kit pins |
| kitTrig | input | 1 | Kit trigger; the code is taken on its rising edge |
| memAddr | output | 10 | Memory address: {program, parameter index, nibble select} |
| dacValue | output | 8 | Assembled parameter value sent to the DAC |
| dacLoad | output | 1 | One-clock DAC load strobe |
| paramSel | output | 3 | Parameter select for the demultiplexers |
| voiceEnN | output | 5 | Active-low voice enables |
| kitCode | output | 3 | Latched kit code |

## Verification
The bench changes the memory data on every clock. The repeated reads at slot positions 2 and 3 therefore return different nibbles from the first reads. A design that latched on a repeat read, or that put the nibbles together in the wrong order, would show a wrong `dacValue`. The tick pattern is varied between every clock, every third clock and irregular gaps, in order to catch a counter that advances without a tick or a load that lasts longer than one clock. Each run passes position 159 several times, so a counter that wraps at 256 or at 159 would drift away from the reference on the next pass. Reset arrives in the same clock as a tick and a trigger edge. The trigger is also held high while `kitBits` changes, which exposes a design that samples the kit code on the level of `kitTrig` rather than on its rising edge.

// File: rtl/drumScanPkg.sv
package drumScanPkg;

  // Positions spent on each parameter slot: low read, high read, two repeats.
  localparam int SLOT_POS = 4;

  // Strobes that pass from the control module to the datapath.
  typedef struct packed {
    logic capLo;    // latch the low nibble
    logic capHi;    // capture the high nibble and issue the load
    logic kitLoad;  // rising edge of the kit trigger was seen
  } scanStrobes_t;

endpackage

// File: rtl/drumScanCtrl.sv
module drumScanCtrl
  import drumScanPkg::*;
#(
  parameter int VOICES = 5,
  parameter int PARAMS = 8,
  localparam int PIDX_W = $clog2(VOICES * PARAMS),
  localparam int SEL_W  = $clog2(PARAMS),
  localparam int VSEL_W = PIDX_W - SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              kitTrig,
  output logic [PIDX_W-1:0] paramIdx,
  output logic              nibSel,
  output logic [SEL_W-1:0]  paramSel,
  output logic [VOICES-1:0] voiceEnN,
  output scanStrobes_t      strobes
);

  localparam int SCAN_LEN = VOICES * PARAMS * SLOT_POS;
  localparam int PH_W     = $clog2(SLOT_POS);
  localparam int CTR_W    = PIDX_W + PH_W;
  localparam logic [CTR_W-1:0] LAST_POS = CTR_W'(SCAN_LEN - 1);
  localparam logic [PH_W-1:0]  PH_LO    = PH_W'(0);
  localparam logic [PH_W-1:0]  PH_HI    = PH_W'(1);
  localparam logic [PH_W-1:0]  PH_DRIVE = PH_W'(SLOT_POS - 1);

  logic [CTR_W-1:0]  scanPos;
  logic [CTR_W-1:0]  scanPosNext;
  logic [PH_W-1:0]   slotPhase;
  logic [PH_W-1:0]   nextPhase;
  logic [VSEL_W-1:0] nextVoice;
  logic              trigPrev;

  // The wrap is an explicit compare because the scan length is not a power of two.
  always_comb begin
    scanPosNext = (scanPos == LAST_POS) ? '0 : scanPos + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scanPos <= '0;
    end else if (tick) begin
      scanPos <= scanPosNext;
    end
  end

  assign slotPhase = scanPos[PH_W-1:0];
  assign nextPhase = scanPosNext[PH_W-1:0];
  assign nextVoice = scanPosNext[CTR_W-1:PH_W+SEL_W];

  // Address fields. Phase bit 1 is deliberately left out of the address.
  assign paramIdx = scanPos[CTR_W-1:PH_W];
  assign nibSel   = scanPos[0];
  assign paramSel = scanPos[PH_W+SEL_W-1:PH_W];

  // Voice enables are registered so that they open one position after the load.
  for (genvar v = 0; v < VOICES; v++) begin : gVoiceEn
    always_ff @(posedge clk) begin
      if (rst) begin
        voiceEnN[v] <= 1'b1;
      end else if (tick) begin
        voiceEnN[v] <= !((nextPhase == PH_DRIVE) && (nextVoice == VSEL_W'(v)));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trigPrev <= 1'b0;
    end else begin
      trigPrev <= kitTrig;
    end
  end

  always_comb begin
    strobes.capLo   = !rst && tick && (slotPhase == PH_LO);
    strobes.capHi   = !rst && tick && (slotPhase == PH_HI);
    strobes.kitLoad = !rst && kitTrig && !trigPrev;
  end

endmodule

// File: rtl/drumScanData.sv
module drumScanData
  import drumScanPkg::*;
#(
  parameter int NIB_W = 4,
  parameter int KIT_W = 3,
  localparam int VAL_W = 2 * NIB_W
) (
  input  logic             clk,
  input  logic             rst,
  input  scanStrobes_t     strobes,
  input  logic [NIB_W-1:0] memData,
  input  logic [KIT_W-1:0] kitBits,
  output logic [VAL_W-1:0] dacValue,
  output logic             dacLoad,
  output logic [KIT_W-1:0] kitCode
);

  logic [NIB_W-1:0] loNib;

  always_ff @(posedge clk) begin
    if (rst) begin
      loNib <= '0;
    end else if (strobes.capLo) begin
      loNib <= memData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dacValue <= '0;
    end else if (strobes.capHi) begin
      dacValue <= {memData, loNib};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dacLoad <= 1'b0;
    end else begin
      dacLoad <= strobes.capHi;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kitCode <= '0;
    end else if (strobes.kitLoad) begin
      kitCode <= kitBits;
    end
  end

endmodule

// File: rtl/drumScanSeq.sv
module drumScanSeq
  import drumScanPkg::*;
#(
  parameter int PROG_W = 3,
  parameter int KIT_W  = 3,
  parameter int NIB_W  = 4,
  parameter int VOICES = 5,
  parameter int PARAMS = 8,
  localparam int PIDX_W = $clog2(VOICES * PARAMS),
  localparam int SEL_W  = $clog2(PARAMS),
  localparam int ADDR_W = PROG_W + PIDX_W + 1,
  localparam int VAL_W  = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [PROG_W-1:0] progSel,
  input  logic [NIB_W-1:0]  memData,
  input  logic [KIT_W-1:0]  kitBits,
  input  logic              kitTrig,
  output logic [ADDR_W-1:0] memAddr,
  output logic [VAL_W-1:0]  dacValue,
  output logic              dacLoad,
  output logic [SEL_W-1:0]  paramSel,
  output logic [VOICES-1:0] voiceEnN,
  output logic [KIT_W-1:0]  kitCode
);

  scanStrobes_t      strobes;
  logic [PIDX_W-1:0] paramIdx;
  logic              nibSel;

  drumScanCtrl #(
    .VOICES(VOICES),
    .PARAMS(PARAMS)
  ) ctrl (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .kitTrig  (kitTrig),
    .paramIdx (paramIdx),
    .nibSel   (nibSel),
    .paramSel (paramSel),
    .voiceEnN (voiceEnN),
    .strobes  (strobes)
  );

  drumScanData #(
    .NIB_W(NIB_W),
    .KIT_W(KIT_W)
  ) data (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .memData  (memData),
    .kitBits  (kitBits),
    .dacValue (dacValue),
    .dacLoad  (dacLoad),
    .kitCode  (kitCode)
  );

  assign memAddr = {progSel, paramIdx, nibSel};

endmodule

// File: rtl/drumScanChecker.sv
module drumScanChecker #(
  parameter int PROG_W = 3,
  parameter int KIT_W  = 3,
  parameter int NIB_W  = 4,
  parameter int VOICES = 5,
  parameter int PARAMS = 8,
  localparam int PIDX_W = $clog2(VOICES * PARAMS),
  localparam int SEL_W  = $clog2(PARAMS),
  localparam int ADDR_W = PROG_W + PIDX_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              kitTrig,
  input logic [ADDR_W-1:0] memAddr,
  input logic              dacLoad,
  input logic [SEL_W-1:0]  paramSel,
  input logic [VOICES-1:0] voiceEnN,
  input logic [KIT_W-1:0]  kitCode
);

  localparam int POS_W = ADDR_W - PROG_W;

  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    dacLoad |=> !dacLoad); // R7

  AST_ENABLE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~voiceEnN)); // R9

  AST_ENABLE_IDLE_AT_LOAD: assert property (@(posedge clk) disable iff (rst)
    dacLoad |-> (&voiceEnN)); // R9

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(memAddr[POS_W-1:0]) && $stable(paramSel))); // R2

  AST_SCAN_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick && !voiceEnN[VOICES-1] && (paramSel == SEL_W'(PARAMS - 1)))
      |=> (memAddr[POS_W-1:0] == '0)); // R4

  AST_KIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !kitTrig |=> $stable(kitCode)); // R10

endmodule

bind drumScanSeq drumScanChecker #(
  .PROG_W(PROG_W),
  .KIT_W (KIT_W),
  .NIB_W (NIB_W),
  .VOICES(VOICES),
  .PARAMS(PARAMS)
) chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .kitTrig  (kitTrig),
  .memAddr  (memAddr),
  .dacLoad  (dacLoad),
  .paramSel (paramSel),
  .voiceEnN (voiceEnN),
  .kitCode  (kitCode)
);

// File: tb/tb_drumScanSeq.sv
module tb_drumScanSeq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [2:0] progSel = 3'd0;
  logic [3:0] memData;
  logic [2:0] kitBits = 3'd0;
  logic       kitTrig = 1'b0;
  logic [9:0] memAddr;
  logic [7:0] dacValue;
  logic       dacLoad;
  logic [2:0] paramSel;
  logic [4:0] voiceEnN;
  logic [2:0] kitCode;
  logic [3:0] noise = 4'd0;

  int checkCount = 0;
  int failCount  = 0;
  bit done = 1'b0;

  // Reference model state
  int mPos = 0;
  int mLo = 0;
  int mDac = 0;
  bit mLoad = 1'b0;
  int mKit = 0;
  bit mPrevTrig = 1'b0;
  bit wrapped = 1'b0;

  always #5 clk = ~clk;

  drumScanSeq dut (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .progSel  (progSel),
    .memData  (memData),
    .kitBits  (kitBits),
    .kitTrig  (kitTrig),
    .memAddr  (memAddr),
    .dacValue (dacValue),
    .dacLoad  (dacLoad),
    .paramSel (paramSel),
    .voiceEnN (voiceEnN),
    .kitCode  (kitCode)
  );

  function automatic logic [3:0] memFn(input logic [9:0] a);
    int v;
    v = int'(a) * 7 + int'(a) / 5 + 3;
    return v[3:0];
  endfunction

  function automatic logic [9:0] expAddr(input int pos, input logic [2:0] prog);
    logic [5:0] idx;
    idx = 6'(pos / 4);
    return {prog, idx, 1'(pos % 2)};
  endfunction

  assign memData = memFn(memAddr) ^ noise;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model and per-clock comparison
  always @(posedge clk) begin
    logic [3:0] nib;
    nib = memFn(expAddr(mPos, progSel)) ^ noise;
    wrapped = 1'b0;
    if (rst) begin
      mPos = 0; mLo = 0; mDac = 0; mLoad = 1'b0; mKit = 0; mPrevTrig = 1'b0;
    end else begin
      mLoad = 1'b0;
      if (tick) begin
        if (mPos % 4 == 0) mLo = int'(nib);
        if (mPos % 4 == 1) begin
          mDac = int'(nib) * 16 + mLo;
          mLoad = 1'b1;
        end
        if (mPos == 159) begin
          mPos = 0;
          wrapped = 1'b1;
        end else begin
          mPos = mPos + 1;
        end
      end
      if (kitTrig && !mPrevTrig) mKit = int'(kitBits);
      mPrevTrig = kitTrig;
    end
    #2;
    if (!done) begin
      chk("R2 R3 address position", 32'(memAddr[6:0]), 32'(expAddr(mPos, progSel) & 10'h7f));
      chk("R5 program field", 32'(memAddr[9:7]), 32'(progSel));
      chk("R8 parameter select", 32'(paramSel), 32'((mPos / 4) % 8));
      chk("R9 voice enables", 32'(voiceEnN),
          (mPos % 4 == 3) ? 32'(~(5'b1 << ((mPos / 4) / 8)) & 5'h1f) : 32'h1f);
      chk("R7 load strobe", 32'(dacLoad), 32'(mLoad));
      chk("R6 assembled value", 32'(dacValue), 32'(mDac));
      chk("R10 kit code", 32'(kitCode), 32'(mKit));
      if (wrapped) chk("R4 wrap to position zero", 32'(memAddr[6:0]), 32'd0);
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failCount++;
      checkCount++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  initial begin
    int lfsr;
    lfsr = 32'h1d3;
    // R1: cleared state during reset
    repeat (3) @(negedge clk);
    chk("R1 reset dacValue", 32'(dacValue), 32'd0);
    chk("R1 reset dacLoad", 32'(dacLoad), 32'd0);
    chk("R1 reset voiceEnN", 32'(voiceEnN), 32'h1f);
    chk("R1 reset kitCode", 32'(kitCode), 32'd0);
    chk("R1 reset position", 32'(memAddr[6:0]), 32'd0);
    rst = 1'b0;

    // Tick on every clock, bank 3, with kit triggers
    progSel = 3'd3;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      noise = 4'(i * 3);
      tick = 1'b1;
      kitBits = 3'(i / 7);
      kitTrig = ((i % 37) >= 30);
    end

    // Tick every third clock, bank 0 (program 8)
    progSel = 3'd0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      noise = 4'(i * 5 + 1);
      tick = (i % 3 == 0);
      kitBits = 3'(i);
      kitTrig = ((i % 50) >= 45);
    end

    // R11: reset together with tick and a trigger edge
    @(negedge clk);
    kitTrig = 1'b0;
    @(negedge clk);
    rst = 1'b1; tick = 1'b1; kitTrig = 1'b1; kitBits = 3'd5;
    @(negedge clk);
    chk("R11 reset priority kitCode", 32'(kitCode), 32'd0);
    chk("R11 reset priority position", 32'(memAddr[6:0]), 32'd0);
    chk("R11 reset priority load", 32'(dacLoad), 32'd0);
    chk("R11 reset priority enables", 32'(voiceEnN), 32'h1f);
    rst = 1'b0; kitTrig = 1'b0;

    // Irregular ticks, changing banks
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hb400 : 0);
      noise = 4'(lfsr);
      tick = (lfsr[2:0] != 3'd0);
      if (i % 50 == 0) progSel = 3'(i / 50);
      kitBits = 3'(lfsr >> 4);
      kitTrig = ((i % 23) < 3);
    end

    // R10: trigger held high while kit pins change
    @(negedge clk);
    kitTrig = 1'b1; kitBits = 3'd6; tick = 1'b0;
    @(negedge clk);
    chk("R10 kit taken on edge", 32'(kitCode), 32'd6);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      kitBits = 3'(i);
    end
    @(negedge clk);
    chk("R10 kit held while trigger high", 32'(kitCode), 32'd6);
    kitTrig = 1'b0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule